// File: doc/BRIEF.md
# Baseband Observation Hang Matcher

This block decides whether a baseband has locked up by watching a 32-bit observation word that the baseband exports. A one-cycle start pulse latches the word present in that cycle as a reference. The word is then compared with the reference on each of the following `STABLE_READS` clock edges (50 by default). Any difference ends the check at once with the verdict "no hang", because a moving word means the baseband is still alive.

If the word holds still for the whole window, the latched reference is tested against four fixed mask/value hang signatures in a set priority order. The first entry that matches gives the reported hang class. A frozen word that matches none of the entries is reported as an unknown hang. The verdict shows up with a one-cycle done strobe and then stays on the outputs until the next accepted start. The observation word comes from elsewhere; this block only judges it.

Top module: `obs_hang_matcher`

## Requirements
- R1: While reset is asserted and after it is released, `done` is 0, `hangFlag` is 0 and `hangClass` is 3'b000 (none), until a check completes.
- R2: A start pulse seen while idle latches `obsWord` at that clock edge. The word is then sampled on the next `STABLE_READS` edges. If all samples equal the latched value, `done` is 1 in the cycle after the `STABLE_READS`-th sampling edge and is 0 in the cycle before it.
- R3: If the sample at edge k (1 ≤ k ≤ `STABLE_READS`) after the start edge differs from the latched word, the check ends at that edge. In the following cycle `done` is 1, `hangClass` is 3'b000 and `hangFlag` is 0.
- R4: A stable word with (word & 32'h7E000B00) == 32'h1E000000 is classed as a DFS hang, code 3'b001.
- R5: A stable word with (word & 32'h7E000B00) == 32'h52000B00 is classed as a RIFS hang, code 3'b010.
- R6: Two entries both give the RX-clear hang class, code 3'b011: (word & 32'h7E000B00) == 32'h18000B00, and (word & 32'h7E7FFFEF) == 32'h00702400.
- R7: The entries are tested in the order DFS, RIFS, RX-clear (first form), RX-clear (second form), and the earliest matching entry sets the class. A stable word that matches no entry is reported as unknown, code 3'b100.
- R8: `hangFlag` is 1 exactly when `hangClass` is not 3'b000.
- R9: `done` is high for one cycle only. `hangClass` and `hangFlag` then hold their values, whatever `obsWord` does, until the next accepted start. The accepted start clears them to none in the cycle after its edge.
- R10: A start pulse that arrives while a check is running is ignored. The running check ends at its original edge with its original verdict.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Single-cycle request to begin a check |
| obsWord | input | 32 | Baseband observation word under test |
| done | output | 1 | One-cycle strobe when a verdict is ready |
| hangFlag | output | 1 | High when the verdict is any hang |
| hangClass | output | 3 | 000 none, 001 DFS, 010 RIFS, 011 RX-clear, 100 unknown |

## Verification
A window counter that is off by one moves the done strobe one cycle early or late. It also lets a change in the word on the final sample pass without notice, so the bench disturbs the word exactly at the first, middle and last sample positions and checks the done edge to the cycle. A wrong reference latch or a broken priority pick shows up in the class code as soon as done rises. For that reason every signature base is swept with each of its 32 bits flipped in turn, and the expected class is computed from the masks. A state machine that wrongly honours a restart, or lets the outputs drift after done, is caught within a few cycles by the mid-check start and the hold checks.

// File: rtl/obs_hang_pkg.sv
package obs_hang_pkg;

  localparam int OBS_W   = 32;
  localparam int NUM_SIG = 4;

  typedef enum logic [2:0] {
    CLS_NONE    = 3'b000,
    CLS_DFS     = 3'b001,
    CLS_RIFS    = 3'b010,
    CLS_RXCLR   = 3'b011,
    CLS_UNKNOWN = 3'b100
  } hangClass_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic capture;    // latch reference, clear verdict
    logic endStable;  // window passed, register classification
    logic endAbort;   // word moved, register "no hang"
  } ctrlStrb_t;

  // Signature table, index 0 has highest priority
  localparam logic [OBS_W-1:0] SIG_MASK [NUM_SIG] = '{
    32'h7E000B00, 32'h7E000B00, 32'h7E000B00, 32'h7E7FFFEF
  };
  localparam logic [OBS_W-1:0] SIG_VAL [NUM_SIG] = '{
    32'h1E000000, 32'h52000B00, 32'h18000B00, 32'h00702400
  };
  localparam hangClass_e SIG_CLASS [NUM_SIG] = '{
    CLS_DFS, CLS_RIFS, CLS_RXCLR, CLS_RXCLR
  };

endpackage

// File: rtl/obs_hang_ctrl.sv
module obs_hang_ctrl
  import obs_hang_pkg::*;
#(
  parameter int STABLE_READS = 50
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      start,
  input  logic      mismatch,
  output ctrlStrb_t strb
);

  localparam int CNT_W = $clog2(STABLE_READS + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(STABLE_READS - 1);

  typedef enum logic {ST_IDLE, ST_CHECK} state_e;

  state_e           state;
  logic [CNT_W-1:0] sampleCnt;

  always_comb begin
    strb = '0;
    case (state)
      ST_IDLE:  strb.capture = start;
      ST_CHECK: begin
        if (mismatch)                strb.endAbort  = 1'b1;
        else if (sampleCnt == LAST)  strb.endStable = 1'b1;
      end
      default: strb = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      sampleCnt <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          sampleCnt <= '0;
          if (start) state <= ST_CHECK;
        end
        ST_CHECK: begin
          if (strb.endAbort || strb.endStable) begin
            state     <= ST_IDLE;
            sampleCnt <= '0;
          end else begin
            sampleCnt <= sampleCnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_CNT_IN_WINDOW: assert property (@(posedge clk) disable iff (!rstN)
    sampleCnt <= LAST); // R2

  AST_MOVE_ENDS_CHECK: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_CHECK && mismatch) |=> state == ST_IDLE); // R3

  AST_BUSY_NO_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_CHECK && start) |=> !strb.capture); // R10

endmodule

// File: rtl/obs_hang_dp.sv
module obs_hang_dp
  import obs_hang_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrb_t        strb,
  input  logic [OBS_W-1:0] obsWord,
  output logic             mismatch,
  output logic             done,
  output logic             hangFlag,
  output hangClass_e       hangClass
);

  logic [OBS_W-1:0]   refQ;
  logic [NUM_SIG-1:0] hitVec;
  hangClass_e         matchCls;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            refQ <= '0;
    else if (strb.capture) refQ <= obsWord;
  end

  assign mismatch = (obsWord != refQ);

  // One comparator per table entry
  for (genvar g = 0; g < NUM_SIG; g++) begin : gSig
    assign hitVec[g] = ((refQ & SIG_MASK[g]) == SIG_VAL[g]);
  end

  // Walk from lowest priority up so the lowest index wins
  always_comb begin
    matchCls = CLS_UNKNOWN;
    for (int i = NUM_SIG - 1; i >= 0; i--) begin
      if (hitVec[i]) matchCls = SIG_CLASS[i];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      done      <= 1'b0;
      hangFlag  <= 1'b0;
      hangClass <= CLS_NONE;
    end else begin
      done <= strb.endStable | strb.endAbort;
      if (strb.capture || strb.endAbort) begin
        hangFlag  <= 1'b0;
        hangClass <= CLS_NONE;
      end else if (strb.endStable) begin
        hangFlag  <= (matchCls != CLS_NONE);
        hangClass <= matchCls;
      end
    end
  end

  AST_ABORT_GIVES_NONE: assert property (@(posedge clk) disable iff (!rstN)
    strb.endAbort |=> (done && hangClass == CLS_NONE)); // R3

  AST_FLAG_TRACKS_CLASS: assert property (@(posedge clk) disable iff (!rstN)
    hangFlag == (hangClass != CLS_NONE)); // R8

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R9

  AST_VERDICT_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.capture || strb.endStable || strb.endAbort) |=> $stable(hangClass)); // R9

endmodule

// File: rtl/obs_hang_matcher.sv
module obs_hang_matcher
  import obs_hang_pkg::*;
#(
  parameter int STABLE_READS = 50
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic [31:0] obsWord,
  output logic        done,
  output logic        hangFlag,
  output logic [2:0]  hangClass
);

  ctrlStrb_t  strb;
  logic       mismatch;
  hangClass_e clsQ;

  obs_hang_ctrl #(.STABLE_READS(STABLE_READS)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .mismatch (mismatch),
    .strb     (strb)
  );

  obs_hang_dp u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .obsWord   (obsWord),
    .mismatch  (mismatch),
    .done      (done),
    .hangFlag  (hangFlag),
    .hangClass (clsQ)
  );

  assign hangClass = clsQ;

endmodule

// File: tb/obs_hang_matcher_bench.sv
module obs_hang_matcher_bench;

  localparam int STABLE = 50;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [31:0] obsWord = '0;
  logic        done;
  logic        hangFlag;
  logic [2:0]  hangClass;

  int nRun = 0;
  int nFail = 0;

  always #4 clk = ~clk;  // 125 MHz

  obs_hang_matcher #(.STABLE_READS(STABLE)) u_obs_hang_matcher (
    .clk(clk), .rstN(rstN), .start(start), .obsWord(obsWord),
    .done(done), .hangFlag(hangFlag), .hangClass(hangClass)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [2:0] modelClass(input logic [31:0] w);
    if ((w & 32'h7E000B00) == 32'h1E000000) return 3'b001;
    if ((w & 32'h7E000B00) == 32'h52000B00) return 3'b010;
    if ((w & 32'h7E000B00) == 32'h18000B00) return 3'b011;
    if ((w & 32'h7E7FFFEF) == 32'h00702400) return 3'b011;
    return 3'b100;
  endfunction

  function automatic string classTag(input logic [2:0] c);
    case (c)
      3'b001:  return "R4 DFS";
      3'b010:  return "R5 RIFS";
      3'b011:  return "R6 RX-clear";
      3'b100:  return "R7 unknown";
      default: return "R3 none";
    endcase
  endfunction

  // flipAt in 1..STABLE disturbs that sample; restart issues a start mid-check
  task automatic runCase(input logic [31:0] w, input int flipAt, input bit restart);
    bit           moved  = (flipAt >= 1 && flipAt <= STABLE);
    int           endAt  = moved ? flipAt : STABLE;
    logic [2:0]   expCls = moved ? 3'b000 : modelClass(w);
    string        tag    = moved ? "R3 moved" : classTag(expCls);
    @(negedge clk);
    obsWord = w;
    start   = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(hangClass == 3'b000 && !hangFlag, "R9 start clears verdict", {29'd0, hangClass}, 0);
    for (int i = 1; i <= endAt; i++) begin
      if (i > 1) @(negedge clk);
      if (restart && i == 20) start = 1'b1;
      if (restart && i == 21) start = 1'b0;
      if (i == flipAt) obsWord = w ^ 32'h0000_0100;
    end
    chk(done == 1'b0, "R2 done not early", {31'd0, done}, 0);
    @(negedge clk);
    chk(done == 1'b1, restart ? "R10 done at original edge" : "R2 done edge", {31'd0, done}, 1);
    chk(hangClass == expCls, tag, {29'd0, hangClass}, {29'd0, expCls});
    chk(hangFlag == (expCls != 3'b000), "R8 flag", {31'd0, hangFlag}, {31'd0, expCls != 3'b000});
    @(negedge clk);
    chk(done == 1'b0, "R9 done one cycle", {31'd0, done}, 0);
    obsWord = ~w;
    repeat (3) @(negedge clk);
    chk(hangClass == expCls, "R9 verdict holds", {29'd0, hangClass}, {29'd0, expCls});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    logic [31:0] bases [4];
    bases = '{32'h1E000000, 32'h52000B00, 32'h18000B00, 32'h00702400};
    repeat (3) @(negedge clk);
    chk(!done && !hangFlag && hangClass == 3'b000, "R1 reset state", {29'd0, hangClass}, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    chk(!done && !hangFlag && hangClass == 3'b000, "R1 after release", {29'd0, hangClass}, 0);

    // Each signature base, then every single-bit flip of it
    for (int e = 0; e < 4; e++) begin
      runCase(bases[e], 0, 1'b0);
      for (int b = 0; b < 32; b++) runCase(bases[e] ^ (32'd1 << b), 0, 1'b0);
    end
    // Don't-care bits set around each base
    for (int e = 0; e < 4; e++) runCase(bases[e] | 32'h81FFF400 & ~(e == 3 ? 32'h7E7FFFEF : 32'h7E000B00), 0, 1'b0);
    // R7 unknown words
    runCase(32'h0000_0000, 0, 1'b0);
    runCase(32'hFFFF_FFFF, 0, 1'b0);
    // R3 instability at first, middle and last sample; beyond window is no effect
    runCase(bases[0], 1, 1'b0);
    runCase(bases[1], 2, 1'b0);
    runCase(bases[2], 25, 1'b0);
    runCase(bases[3], 49, 1'b0);
    runCase(bases[0], STABLE, 1'b0);
    runCase(bases[0], STABLE + 1, 1'b0);
    // R10 start while busy
    runCase(bases[1], 0, 1'b1);
    runCase(32'h1234_5678, 0, 1'b1);
    // Random stable words
    for (int n = 0; n < 60; n++) runCase($urandom(), 0, 1'b0);

    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule